// File: doc/BRIEF.md
# Periodic real-time tick generator

This block turns the bus clock into a periodic tick for software timekeeping. A free-running binary divider counts bus clock cycles. A fixed base stage divides by 2^BASE_BITS (2^13 by default). This base rate is independent of any other timer prescaler. A 2-bit rate code then picks an extra divide of 1, 2, 4 or 8. Each time the selected period ends, a sticky tick flag is set. With a 2 MHz bus clock and the default base, the four periods come to roughly 4.10, 8.19, 16.38 and 32.77 ms.

Software can work in either of two ways. It can poll the flag with the interrupt enable at zero. Or it can set the enable so that a level interrupt request follows the flag. Either way, software acknowledges a tick by writing a one into the flag's bit position. The divider is never restarted by register writes, so changing the rate code does not disturb the time base. The block runs on the bus clock with a synchronous, active-high reset.

There are two registers, both reached through the write port:
- **Control register** (`wr_sel`=0): bits [1:0] hold the rate code and bit 6 holds the interrupt enable.
- **Status register** (`wr_sel`=1): bit 6 is the tick flag.

Top module: `rti_tick_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, the flag, the interrupt request, the interrupt enable and the rate code (00) are all zero.
- R2: With rate code 00, the flag first becomes one exactly 2^BASE_BITS bus clock edges after reset is released.
- R3: Rate codes 01, 10 and 11 stretch the period to 2, 4 and 8 times 2^BASE_BITS cycles. A code written in the first cycle after reset gives its first flag set at edge 2^(BASE_BITS+code).
- R4: The flag is set at the end of every period whether or not the interrupt enable is set. With the enable at zero, the interrupt request stays zero while the flag is one.
- R5: The flag is cleared by a write to the status register with bit 6 at one. A status write with bit 6 at zero leaves the flag as it was, and so does any control-register write.
- R6: If a period ends in the same cycle as a clearing write, the flag ends up one.
- R7: The interrupt request is high exactly when both the flag and the enable are one. It falls in the cycle after a clearing write or after a write that drops the enable.
- R8: A rate code change does not restart the divider. The next flag set comes at the first point where the free-running count completes a whole period of the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | 8 | Write data: control [1:0] rate code, [6] enable; status [6] one clears the flag |
| flag_o | output | 1 | Sticky tick flag, readable by software |
| irq_o | output | 1 | Level interrupt request |

## Verification
Directed runs from reset with each of the four rate codes tell a correct divide factor from an off-by-one or wrong-tap period. They do this by sampling the flag one edge before and exactly at the expected set edge. A mid-period change from code 00 to code 10 tells a free-running divider from one that restarts on the write. A clear placed on the very edge where a period ends separates set-priority from clear-priority. Long random mixes of control writes, status writes with random data, and idle cycles then compare the flag and the request every cycle against a model built from modular cycle counts. This exposes any write that disturbs the flag or the enable when it should not.

// File: rtl/rti_tick_gen.sv
module rti_tick_gen #(
  parameter int BASE_BITS = 13,
  parameter int RATE_BITS = 2,
  parameter int DW        = 8,
  parameter int FLAG_BIT  = 6,
  parameter int EN_BIT    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          flag_o,
  output logic          irq_o
);
  localparam int NRATE = 2 ** RATE_BITS;
  localparam int CNT_W = BASE_BITS + NRATE - 1;

  logic [CNT_W-1:0]     div_q;
  logic [RATE_BITS-1:0] rate_q;
  logic                 en_q;
  logic                 flag_q;
  logic [NRATE-1:0]     hit;
  logic                 tick;
  logic                 ctl_wr;
  logic                 clr;

  for (genvar g = 0; g < NRATE; g++) begin : g_tap
    assign hit[g] = &div_q[BASE_BITS+g-1:0];
  end

  assign tick   = hit[rate_q];
  assign ctl_wr = wr_en && !wr_sel;
  assign clr    = wr_en && wr_sel && wr_data[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      rate_q <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      if (ctl_wr) begin
        rate_q <= wr_data[RATE_BITS-1:0];
        en_q   <= wr_data[EN_BIT];
      end
      if (tick)     flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && en_q;
endmodule

// File: rtl/rti_tick_gen_chk.sv
module rti_tick_gen_chk #(
  parameter int DW       = 8,
  parameter int FLAG_BIT = 6,
  parameter int EN_BIT   = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          wr_sel,
  input logic [DW-1:0] wr_data,
  input logic          tick,
  input logic          flag_o,
  input logic          irq_o
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (!flag_o && !irq_o));

  p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !tick) |=> !flag_o);

  p_tick_sets_r6: assert property (@(posedge clk) disable iff (rst)
    tick |=> flag_o);

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && wr_data[FLAG_BIT] && !tick) |=> !flag_o);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !(wr_en && wr_sel && wr_data[FLAG_BIT])) |=> flag_o);

  p_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && !wr_data[EN_BIT]) |=> !irq_o);

  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> !irq_o);

  p_need_flag_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
endmodule

bind rti_tick_gen rti_tick_gen_chk #(.DW(DW), .FLAG_BIT(FLAG_BIT), .EN_BIT(EN_BIT)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .tick(tick), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/test_rti_tick_gen.sv
module test_rti_tick_gen;
  localparam int BB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int mcnt = 0, mrate = 0;
  bit mflag = 1'b0, men = 1'b0;

  rti_tick_gen #(.BASE_BITS(BB)) i_rti_tick_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  function automatic bit period_ends(int cnt, int rate);
    return ((cnt + 1) % (1 << (BB + rate))) == 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cyc <= 0; mcnt <= 0; mrate <= 0; men <= 1'b0; mflag <= 1'b0;
    end else begin
      cyc  <= cyc + 1;
      mcnt <= (mcnt + 1) % (1 << (BB + 3));
      if (period_ends(mcnt, mrate)) mflag <= 1'b1;
      else if (wr_en && wr_sel && wr_data[6]) mflag <= 1'b0;
      if (wr_en && !wr_sel) begin
        mrate <= int'(wr_data[1:0]);
        men   <= wr_data[6];
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(flag_o == mflag, "R4/R5/R8 flag vs model", flag_o, mflag);
      chk(irq_o == (mflag && men), "R7 irq vs model", irq_o, mflag && men);
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic go(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(10 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk); @(negedge clk);
    chk(flag_o == 1'b0, "R1 flag in reset", flag_o, 0);
    chk(irq_o == 1'b0, "R1 irq in reset", irq_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(flag_o == 1'b0 && irq_o == 1'b0, "R1 after reset", flag_o | irq_o, 0);

    // R2 and R4: default code, enable off
    go((1 << BB) - 1);
    chk(flag_o == 1'b0, "R2 one edge early", flag_o, 0);
    go(1 << BB);
    chk(flag_o == 1'b1, "R2 first set", flag_o, 1);
    chk(irq_o == 1'b0, "R4 no request when disabled", irq_o, 0);

    // R5: non-clearing writes
    wr(1'b1, 8'hBF);
    chk(flag_o == 1'b1, "R5 bit6 zero keeps flag", flag_o, 1);
    wr(1'b0, 8'h40);
    chk(flag_o == 1'b1, "R5 control write keeps flag", flag_o, 1);
    // R7: enable raises request
    chk(irq_o == 1'b1, "R7 request with enable", irq_o, 1);
    wr(1'b1, 8'h40);
    chk(flag_o == 1'b0, "R5 clear by bit6", flag_o, 0);
    chk(irq_o == 1'b0, "R7 request drops after clear", irq_o, 0);

    // R6: clear in the cycle a period ends (edge 2*2^BB)
    go(2 * (1 << BB) - 1);
    wr(1'b1, 8'h40);
    chk(flag_o == 1'b1, "R6 set wins over clear", flag_o, 1);
    wr(1'b0, 8'h00);
    chk(irq_o == 1'b0, "R7 request drops with enable", irq_o, 0);

    // R3: each slower code from reset
    for (int k = 1; k < 4; k++) begin
      do_reset();
      wr(1'b0, 8'(k));
      go((1 << (BB + k)) - 1);
      chk(flag_o == 1'b0, $sformatf("R3 code %0d early", k), flag_o, 0);
      go(1 << (BB + k));
      chk(flag_o == 1'b1, $sformatf("R3 code %0d set", k), flag_o, 1);
    end

    // R8: switch to code 10 mid-period, divider keeps running
    do_reset();
    go((1 << BB) + 1);
    wr(1'b1, 8'h40);
    go((1 << BB) + 4);
    wr(1'b0, 8'h02);
    go(2 * (1 << BB));
    chk(flag_o == 1'b0, "R8 old boundary skipped", flag_o, 0);
    go(4 * (1 << BB) - 1);
    chk(flag_o == 1'b0, "R8 before new boundary", flag_o, 0);
    go(4 * (1 << BB));
    chk(flag_o == 1'b1, "R8 new boundary from running count", flag_o, 1);

    // random mix checked against the model every cycle
    do_reset();
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) wr(1'b0, 8'($urandom));
      else if (r < 3) wr(1'b1, 8'($urandom));
      else @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule